// File: doc/BRIEF.md
# Machine-Mode Trap Sequencer with Fixed Vector Table

This block keeps the machine-level trap state of a small 32-bit core and decides where instruction fetch goes when an exception is raised, an interrupt is accepted or a trap-return strobe arrives. Every trap is vectored. The target is a base address taken from the vector-base register with its low `ALIGN_BITS` bits cleared, plus a fixed offset that depends on the cause. Interrupt lines occupy the first 32 word slots. A short group of fixed slots follows them, for reset and for the three exception kinds.

The pipeline presents the current PC, the interrupt request lines and one-cycle exception pulses with an optional faulting value. In the same cycle it may drive the return strobe and a CSR access. One cycle later the block raises `redirect_o` together with `target_o`. By that time the saved PC, the cause, the fault value and the interrupt-enable pair have already been updated. The block saves no general-purpose registers and never switches stacks; that work belongs to the handler software.

Top module: `trap_vec_unit`

## Requirements
- R1: While reset is asserted, `redirect_o` is 1, `target_o` equals `MTVEC_RST` with its low `ALIGN_BITS` bits cleared plus 0x80, and the status register (address 0x300) reads 0.
- R2: The vector-base register (0x305) stores only bits 31..`ALIGN_BITS`. The low bits always read back 0, and any mode bits written there never change a trap target.
- R3: A taken trap writes the PC into the saved-PC register (0x341), copies the enable bit MIE (status bit 3) into MPIE (status bit 7), clears MIE, and raises `redirect_o` in the following cycle.
- R4: The trap target is the base plus an offset. Interrupt line N goes to N*4, an illegal instruction to 0x84, an environment call to 0x88 and a load/store fault to 0x8C.
- R5: The cause register (0x342) receives 0x80000000|N for interrupt line N. It receives 2 for an illegal instruction, 11 for an environment call, 5 for a load fault and 7 for a store fault.
- R6: The fault-value register (0x343) captures `exc_tval_i` on every exception and is written with 0 on every interrupt.
- R7: Exceptions are taken whatever MIE holds, with illegal ahead of ecall ahead of load/store. Interrupts are taken only when MIE is 1, and then only when no exception is present; the lowest-numbered pending line wins. Any trap outranks a return strobe in the same cycle.
- R8: A return strobe with no trap redirects to the saved PC in the next cycle, sets MIE to the old MPIE and sets MPIE to 1.
- R9: The CSR port accepts op codes 0 read, 1 write, 2 set bits and 3 clear bits. `csr_rdata_o` shows the current (old) value of `csr_addr_i` in the same cycle. The scratch register (0x340), the saved PC, the cause and the fault value are all writable by software.
- R10: A CSR write issued in the same cycle as a taken trap or return has no effect.
- R11: In a cycle with no trap and no return, `redirect_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the instruction in the trap stage |
| irq_i | input | NUM_IRQ | Level interrupt request lines |
| exc_illegal_i | input | 1 | Illegal instruction pulse |
| exc_ecall_i | input | 1 | Environment call pulse |
| exc_lsu_i | input | 1 | Load/store fault pulse |
| lsu_is_store_i | input | 1 | Load/store fault came from a store |
| exc_tval_i | input | 32 | Faulting value for the exception |
| mret_i | input | 1 | Trap-return strobe |
| csr_en_i | input | 1 | CSR access valid |
| csr_op_i | input | 2 | CSR operation code |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write/set/clear operand |
| csr_rdata_o | output | 32 | Old value of the addressed CSR |
| redirect_o | output | 1 | Fetch redirect valid |
| target_o | output | 32 | Fetch redirect address |

## Verification
The bench builds the unit with `NUM_IRQ = 8` and `ALIGN_BITS = 8`, and with a reset base whose low byte is nonzero, so that the masking shows up in the very first redirect. With only eight lines, every one of the 255 nonzero request patterns can be swept with the enable bit set. Each pattern's expected slot, cause and saved PC is computed from its lowest set bit, and each is followed by a return that must restore the enable pair. Directed cases cover the three exception kinds against masked and unmasked interrupts, vector-base mode bits, the set/clear arithmetic and CSR writes that collide with a trap or a return.

// File: rtl/trapu_pkg.sv
package trapu_pkg;

   localparam int unsigned XLEN  = 32;
   localparam int unsigned IDX_W = 5;

   typedef enum logic [1:0] {
      CSR_RD  = 2'd0,
      CSR_WR  = 2'd1,
      CSR_SET = 2'd2,
      CSR_CLR = 2'd3
   } csr_op_e;

   localparam logic [11:0] A_STATUS  = 12'h300;
   localparam logic [11:0] A_TVEC    = 12'h305;
   localparam logic [11:0] A_SCRATCH = 12'h340;
   localparam logic [11:0] A_EPC     = 12'h341;
   localparam logic [11:0] A_CAUSE   = 12'h342;
   localparam logic [11:0] A_TVAL    = 12'h343;

   localparam int unsigned BIT_IE   = 3;
   localparam int unsigned BIT_PIE  = 7;

   localparam logic [7:0] SLOT_RESET   = 8'h80;
   localparam logic [7:0] SLOT_ILLEGAL = 8'h84;
   localparam logic [7:0] SLOT_ECALL   = 8'h88;
   localparam logic [7:0] SLOT_LSU     = 8'h8C;

   localparam logic [XLEN-1:0] CODE_ILLEGAL = 32'd2;
   localparam logic [XLEN-1:0] CODE_ECALL   = 32'd11;
   localparam logic [XLEN-1:0] CODE_LDFAULT = 32'd5;
   localparam logic [XLEN-1:0] CODE_STFAULT = 32'd7;
   localparam logic [XLEN-1:0] IRQ_FLAG     = 32'h8000_0000;

   typedef struct packed {
      logic            take;
      logic            from_irq;
      logic [XLEN-1:0] cause;
      logic [7:0]      slot;
   } trap_sel_t;

endpackage

// File: rtl/trapu_irq_pick.sv
module trapu_irq_pick
   import trapu_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 32
) (
   input  logic [NUM_IRQ-1:0] req_i,
   input  logic               enable_i,
   output logic               hit_o,
   output logic [IDX_W-1:0]   idx_o
);

   generate
      if (NUM_IRQ == 1) begin : g_single
         assign hit_o = enable_i & req_i[0];
         assign idx_o = '0;
      end else begin : g_scan
         always_comb begin
            hit_o = 1'b0;
            idx_o = '0;
            for (int i = int'(NUM_IRQ) - 1; i >= 0; i--) begin
               if (enable_i && req_i[i]) begin
                  hit_o = 1'b1;
                  idx_o = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/trapu_arbiter.sv
module trapu_arbiter
   import trapu_pkg::*;
(
   input  logic             exc_illegal_i,
   input  logic             exc_ecall_i,
   input  logic             exc_lsu_i,
   input  logic             lsu_is_store_i,
   input  logic             irq_hit_i,
   input  logic [IDX_W-1:0] irq_idx_i,
   output trap_sel_t        sel_o
);

   always_comb begin
      sel_o = '0;
      if (exc_illegal_i) begin
         sel_o.take  = 1'b1;
         sel_o.cause = CODE_ILLEGAL;
         sel_o.slot  = SLOT_ILLEGAL;
      end else if (exc_ecall_i) begin
         sel_o.take  = 1'b1;
         sel_o.cause = CODE_ECALL;
         sel_o.slot  = SLOT_ECALL;
      end else if (exc_lsu_i) begin
         sel_o.take  = 1'b1;
         sel_o.cause = lsu_is_store_i ? CODE_STFAULT : CODE_LDFAULT;
         sel_o.slot  = SLOT_LSU;
      end else if (irq_hit_i) begin
         sel_o.take     = 1'b1;
         sel_o.from_irq = 1'b1;
         sel_o.cause    = IRQ_FLAG | XLEN'(irq_idx_i);
         sel_o.slot     = {1'b0, irq_idx_i, 2'b00};
      end
   end

endmodule

// File: rtl/trapu_csr_file.sv
module trapu_csr_file
   import trapu_pkg::*;
#(
   parameter int unsigned     ALIGN_BITS = 8,
   parameter logic [XLEN-1:0] MTVEC_RST  = '0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            csr_en_i,
   input  logic [1:0]      csr_op_i,
   input  logic [11:0]     csr_addr_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   output logic [XLEN-1:0] csr_rdata_o,
   input  logic            trap_take_i,
   input  logic            trap_from_irq_i,
   input  logic [XLEN-1:0] trap_cause_i,
   input  logic [XLEN-1:0] trap_pc_i,
   input  logic [XLEN-1:0] trap_tval_i,
   input  logic            ret_take_i,
   output logic            mie_o,
   output logic            mpie_o,
   output logic [XLEN-1:0] mepc_o,
   output logic [XLEN-1:0] tvec_base_o
);

   localparam int unsigned HI_W = XLEN - ALIGN_BITS;

   logic [HI_W-1:0] tvec_q;
   logic [XLEN-1:0] epc_q, cause_q, tval_q, scratch_q;
   logic            ie_q, pie_q;
   logic [XLEN-1:0] status_view, old_val, new_val;
   logic            wr_en;
   csr_op_e         op;

   assign op = csr_op_e'(csr_op_i);

   always_comb begin
      status_view          = '0;
      status_view[BIT_IE]  = ie_q;
      status_view[BIT_PIE] = pie_q;
   end

   always_comb begin
      unique case (csr_addr_i)
         A_STATUS:  old_val = status_view;
         A_TVEC:    old_val = {tvec_q, {ALIGN_BITS{1'b0}}};
         A_SCRATCH: old_val = scratch_q;
         A_EPC:     old_val = epc_q;
         A_CAUSE:   old_val = cause_q;
         A_TVAL:    old_val = tval_q;
         default:   old_val = '0;
      endcase
   end

   always_comb begin
      unique case (op)
         CSR_WR:  new_val = csr_wdata_i;
         CSR_SET: new_val = old_val | csr_wdata_i;
         CSR_CLR: new_val = old_val & ~csr_wdata_i;
         default: new_val = old_val;
      endcase
   end

   assign wr_en       = csr_en_i && (op != CSR_RD) && !trap_take_i && !ret_take_i;
   assign csr_rdata_o = old_val;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tvec_q    <= MTVEC_RST[XLEN-1:ALIGN_BITS];
         epc_q     <= '0;
         cause_q   <= '0;
         tval_q    <= '0;
         scratch_q <= '0;
         ie_q      <= 1'b0;
         pie_q     <= 1'b0;
      end else if (trap_take_i) begin
         epc_q   <= trap_pc_i;
         cause_q <= trap_cause_i;
         tval_q  <= trap_from_irq_i ? '0 : trap_tval_i;
         pie_q   <= ie_q;
         ie_q    <= 1'b0;
      end else if (ret_take_i) begin
         ie_q  <= pie_q;
         pie_q <= 1'b1;
      end else if (wr_en) begin
         unique case (csr_addr_i)
            A_STATUS: begin
               ie_q  <= new_val[BIT_IE];
               pie_q <= new_val[BIT_PIE];
            end
            A_TVEC:    tvec_q    <= new_val[XLEN-1:ALIGN_BITS];
            A_SCRATCH: scratch_q <= new_val;
            A_EPC:     epc_q     <= new_val;
            A_CAUSE:   cause_q   <= new_val;
            A_TVAL:    tval_q    <= new_val;
            default: ;
         endcase
      end
   end

   assign mie_o       = ie_q;
   assign mpie_o      = pie_q;
   assign mepc_o      = epc_q;
   assign tvec_base_o = {tvec_q, {ALIGN_BITS{1'b0}}};

endmodule

// File: rtl/trap_vec_unit.sv
module trap_vec_unit
   import trapu_pkg::*;
#(
   parameter int unsigned     NUM_IRQ    = 32,
   parameter int unsigned     ALIGN_BITS = 8,
   parameter logic [XLEN-1:0] MTVEC_RST  = 32'h0000_0000
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [31:0]        pc_i,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               exc_illegal_i,
   input  logic               exc_ecall_i,
   input  logic               exc_lsu_i,
   input  logic               lsu_is_store_i,
   input  logic [31:0]        exc_tval_i,
   input  logic               mret_i,
   input  logic               csr_en_i,
   input  logic [1:0]         csr_op_i,
   input  logic [11:0]        csr_addr_i,
   input  logic [31:0]        csr_wdata_i,
   output logic [31:0]        csr_rdata_o,
   output logic               redirect_o,
   output logic [31:0]        target_o
);

   localparam logic [XLEN-1:0] LOW_MASK   = (XLEN'(1) << ALIGN_BITS) - XLEN'(1);
   localparam logic [XLEN-1:0] RST_TARGET = (MTVEC_RST & ~LOW_MASK) | XLEN'(SLOT_RESET);

   generate
      if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_irq
         $error("trap_vec_unit: NUM_IRQ must lie in 1..32");
      end
      if (ALIGN_BITS < 8 || ALIGN_BITS > 30) begin : g_bad_align
         $error("trap_vec_unit: ALIGN_BITS must lie in 8..30");
      end
   endgenerate

   logic             irq_hit;
   logic [IDX_W-1:0] irq_idx;
   trap_sel_t        sel;
   logic             ret_take;
   logic             mie_w, mpie_w;
   logic [XLEN-1:0]  mepc_w, tvec_base_w;
   logic             redirect_q;
   logic [XLEN-1:0]  target_q;

   trapu_irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
      .req_i    (irq_i),
      .enable_i (mie_w),
      .hit_o    (irq_hit),
      .idx_o    (irq_idx)
   );

   trapu_arbiter u_arb (
      .exc_illegal_i  (exc_illegal_i),
      .exc_ecall_i    (exc_ecall_i),
      .exc_lsu_i      (exc_lsu_i),
      .lsu_is_store_i (lsu_is_store_i),
      .irq_hit_i      (irq_hit),
      .irq_idx_i      (irq_idx),
      .sel_o          (sel)
   );

   assign ret_take = mret_i && !sel.take;

   trapu_csr_file #(.ALIGN_BITS(ALIGN_BITS), .MTVEC_RST(MTVEC_RST)) u_csr (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .csr_en_i        (csr_en_i),
      .csr_op_i        (csr_op_i),
      .csr_addr_i      (csr_addr_i),
      .csr_wdata_i     (csr_wdata_i),
      .csr_rdata_o     (csr_rdata_o),
      .trap_take_i     (sel.take),
      .trap_from_irq_i (sel.from_irq),
      .trap_cause_i    (sel.cause),
      .trap_pc_i       (pc_i),
      .trap_tval_i     (exc_tval_i),
      .ret_take_i      (ret_take),
      .mie_o           (mie_w),
      .mpie_o          (mpie_w),
      .mepc_o          (mepc_w),
      .tvec_base_o     (tvec_base_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         redirect_q <= 1'b1;
         target_q   <= RST_TARGET;
      end else if (sel.take) begin
         redirect_q <= 1'b1;
         target_q   <= tvec_base_w | XLEN'(sel.slot);
      end else if (ret_take) begin
         redirect_q <= 1'b1;
         target_q   <= mepc_w;
      end else begin
         redirect_q <= 1'b0;
      end
   end

   assign redirect_o = redirect_q;
   assign target_o   = target_q;

endmodule

// File: rtl/trapu_checker.sv
module trapu_checker #(
   parameter int unsigned NUM_IRQ = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [31:0]        pc_i,
   input logic [NUM_IRQ-1:0] irq_i,
   input logic               exc_illegal_i,
   input logic               exc_ecall_i,
   input logic               exc_lsu_i,
   input logic               mret_i,
   input logic               redirect_o,
   input logic [31:0]        target_o,
   input logic               mie,
   input logic               mpie,
   input logic [31:0]        mepc
);

   logic exc_any, irq_live;
   assign exc_any  = exc_illegal_i | exc_ecall_i | exc_lsu_i;
   assign irq_live = mie && (|irq_i);

   a_r3_entry_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_any |=> (mepc == $past(pc_i)));

   a_r3_entry_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_any || irq_live) |=> (!mie && (mpie == $past(mie)) && redirect_o));

   a_r4_exc_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_any |=> (target_o[7:0] >= 8'h84 && target_o[7:0] <= 8'h8C && target_o[1:0] == 2'b00));

   a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mie && !exc_any && !mret_i) |=> !redirect_o);

   a_r8_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mret_i && !exc_any && !irq_live) |=>
         (redirect_o && target_o == $past(mepc) && mie == $past(mpie) && mpie));

   a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!exc_any && !irq_live && !mret_i) |=> !redirect_o);

endmodule

bind trap_vec_unit trapu_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .pc_i          (pc_i),
   .irq_i         (irq_i),
   .exc_illegal_i (exc_illegal_i),
   .exc_ecall_i   (exc_ecall_i),
   .exc_lsu_i     (exc_lsu_i),
   .mret_i        (mret_i),
   .redirect_o    (redirect_o),
   .target_o      (target_o),
   .mie           (mie_w),
   .mpie          (mpie_w),
   .mepc          (mepc_w)
);

// File: tb/trap_vec_unit_tb.sv
module trap_vec_unit_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned N_IRQ = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [31:0]       pc;
   logic [N_IRQ-1:0]  irq;
   logic              ill, ecall, lsu, lsu_st;
   logic [31:0]       tval;
   logic              mret;
   logic              csr_en;
   logic [1:0]        csr_op;
   logic [11:0]       csr_addr;
   logic [31:0]       csr_wdata, csr_rdata;
   logic              redirect;
   logic [31:0]       target;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   trap_vec_unit #(.NUM_IRQ(N_IRQ), .ALIGN_BITS(8), .MTVEC_RST(32'h0000_1077)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .irq_i(irq),
      .exc_illegal_i(ill), .exc_ecall_i(ecall), .exc_lsu_i(lsu), .lsu_is_store_i(lsu_st),
      .exc_tval_i(tval), .mret_i(mret), .csr_en_i(csr_en), .csr_op_i(csr_op),
      .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
      .redirect_o(redirect), .target_o(target)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      csr_addr = a;
      #0.2;
      v = csr_rdata;
   endtask

   task automatic wr(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] old);
      csr_en = 1'b1; csr_op = op; csr_addr = a; csr_wdata = d;
      #0.2;
      old = csr_rdata;
      tick();
      csr_en = 1'b0; csr_op = 2'd0;
   endtask

   task automatic check_csr(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic do_ret(input string req, input logic [31:0] exp_pc, input logic [31:0] exp_st);
      mret = 1'b1;
      tick();
      mret = 1'b0;
      check({req, " return redirect"}, 32'(redirect), 32'd1);
      check({req, " return target"}, target, exp_pc);
      check_csr({req, " return status"}, 12'h300, exp_st);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] old, base;
      rst_n = 1'b0; pc = '0; irq = '0; ill = 0; ecall = 0; lsu = 0; lsu_st = 0;
      tval = '0; mret = 0; csr_en = 0; csr_op = '0; csr_addr = '0; csr_wdata = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 reset redirect", 32'(redirect), 32'd1);
      check("R1 reset target", target, 32'h0000_1080);
      check_csr("R1 reset status", 12'h300, 32'h0);
      rst_n = 1'b1;
      tick();
      check("R11 idle after reset", 32'(redirect), 32'd0);

      // R2 base masking
      wr(2'd1, 12'h305, 32'h0000_2A57, old);
      check("R2 old tvec", old, 32'h0000_1000);
      check_csr("R2 tvec readback", 12'h305, 32'h0000_2A00);
      base = 32'h0000_2A00;

      // illegal instruction with MIE clear
      pc = 32'h100; tval = 32'hDEAD_BEEF; ill = 1'b1;
      tick();
      ill = 1'b0;
      check("R3 illegal redirect", 32'(redirect), 32'd1);
      check("R4 illegal target", target, base + 32'h84);
      check_csr("R3 illegal epc", 12'h341, 32'h100);
      check_csr("R5 illegal cause", 12'h342, 32'd2);
      check_csr("R6 illegal tval", 12'h343, 32'hDEAD_BEEF);
      check_csr("R3 illegal status", 12'h300, 32'h0);
      tick();
      check("R11 idle after trap", 32'(redirect), 32'd0);

      // R9 software advances the saved PC
      wr(2'd1, 12'h341, 32'h104, old);
      check("R9 epc old value", old, 32'h100);
      do_ret("R8 R9 advanced", 32'h104, 32'h80);

      // R4 R5 R6 other exceptions
      pc = 32'h200; tval = 32'h55; ecall = 1'b1;
      tick(); ecall = 1'b0;
      check("R4 ecall target", target, base + 32'h88);
      check_csr("R5 ecall cause", 12'h342, 32'd11);
      check_csr("R6 ecall tval", 12'h343, 32'h55);
      pc = 32'h204; tval = 32'h4000_0001; lsu = 1'b1; lsu_st = 1'b0;
      tick(); lsu = 1'b0;
      check("R4 load target", target, base + 32'h8C);
      check_csr("R5 load cause", 12'h342, 32'd5);
      check_csr("R6 load tval", 12'h343, 32'h4000_0001);
      pc = 32'h208; tval = 32'h4000_0002; lsu = 1'b1; lsu_st = 1'b1;
      tick(); lsu = 1'b0; lsu_st = 1'b0;
      check("R5 store cause", 32'(redirect), 32'd1);
      check_csr("R5 store cause", 12'h342, 32'd7);

      // R7 interrupts masked while MIE clear
      irq = 8'hFF;
      tick();
      check("R7 masked no redirect", 32'(redirect), 32'd0);
      check_csr("R7 masked cause kept", 12'h342, 32'd7);
      irq = '0;

      // R9 set bits enables interrupts
      wr(2'd2, 12'h300, 32'h8, old);
      check("R9 set old status", old, 32'h0);
      check_csr("R9 set status", 12'h300, 32'h8);

      // R4 R5 R7 sweep of all request patterns
      for (int p = 1; p < 256; p++) begin
         int low;
         low = 0;
         for (int b = 7; b >= 0; b--) if (p[b]) low = b;
         pc = 32'h1000 + 32'(p) * 4;
         irq = 8'(p);
         tick();
         irq = '0;
         check("R3 irq redirect", 32'(redirect), 32'd1);
         check("R4 R7 irq target", target, base + 32'(low) * 4);
         check_csr("R5 irq cause", 12'h342, 32'h8000_0000 | 32'(low));
         check_csr("R6 irq tval", 12'h343, 32'h0);
         check_csr("R3 irq epc", 12'h341, pc);
         check_csr("R3 irq status", 12'h300, 32'h80);
         do_ret("R8 irq", pc, 32'h88);
      end

      // R7 exception beats interrupt, illegal beats ecall
      pc = 32'h500; irq = 8'h10; ill = 1'b1; ecall = 1'b1; tval = 32'h77;
      tick();
      ill = 1'b0; ecall = 1'b0; irq = '0;
      check("R7 exc over irq target", target, base + 32'h84);
      check_csr("R7 exc over irq cause", 12'h342, 32'd2);
      check_csr("R3 exc status", 12'h300, 32'h80);
      do_ret("R8 after exc", 32'h500, 32'h88);

      // R7 trap beats return
      pc = 32'h600; ecall = 1'b1; mret = 1'b1;
      tick();
      ecall = 1'b0; mret = 1'b0;
      check("R7 trap over return target", target, base + 32'h88);
      check_csr("R7 trap over return status", 12'h300, 32'h80);
      do_ret("R8 after ecall", 32'h600, 32'h88);

      // R9 write / set / clear on scratch
      wr(2'd1, 12'h340, 32'h0000_F0F0, old);
      check("R9 scratch initial", old, 32'h0);
      wr(2'd2, 12'h340, 32'h0000_000F, old);
      check("R9 set old", old, 32'h0000_F0F0);
      check_csr("R9 set result", 12'h340, 32'h0000_F0FF);
      wr(2'd3, 12'h340, 32'h0000_F000, old);
      check_csr("R9 clear result", 12'h340, 32'h0000_00FF);
      wr(2'd0, 12'h340, 32'hFFFF_FFFF, old);
      check_csr("R9 read op no write", 12'h340, 32'h0000_00FF);

      // R10 CSR writes blocked by trap and return
      pc = 32'h700; ill = 1'b1;
      wr(2'd1, 12'h340, 32'h1234, old);
      ill = 1'b0;
      check_csr("R10 scratch unchanged by trap", 12'h340, 32'h0000_00FF);
      check_csr("R10 epc from trap", 12'h341, 32'h700);
      mret = 1'b1;
      wr(2'd1, 12'h341, 32'h999, old);
      mret = 1'b0;
      check("R10 return target", target, 32'h700);
      check_csr("R10 epc unchanged by return", 12'h341, 32'h700);

      // R2 mode bits ignored for targets
      wr(2'd1, 12'h305, 32'h0000_3001, old);
      check_csr("R2 mode bits dropped", 12'h305, 32'h0000_3000);
      pc = 32'h800; ecall = 1'b1;
      tick(); ecall = 1'b0;
      check("R2 R4 vectored target", target, 32'h0000_3088);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule